// File: doc/BRIEF.md
# DDR SDRAM Power-Up Initialization Sequencer

This block sits on the controller side of a DDR SDRAM interface. It runs the command sequence that the memory needs after power-up, once the supplies and the clock are stable. After reset it keeps the clock enable low and the chip deselected for a start-up interval. It then raises the clock enable, precharges every bank and loads the extended mode register to turn the delay-locked loop on. Next it loads the mode register with the DLL-reset bit set, precharges again, runs two auto-refresh cycles and loads the mode register a final time with the DLL-reset bit clear.

Every wait is set by a parameter in nanoseconds and converted to clock cycles when the design is elaborated. The conversion uses the clock period parameter and always rounds up. The done flag tells the main controller that it may start normal traffic. The flag is held back until the DLL-lock window has passed, counted from the cycle that carries the DLL-reset load. Since reads can only start after done, this window also keeps reads away from the DLL reset.

Top module: `ddr_pwrup_seq`

## Requirements
- R1: From reset, and for exactly N = ceil(T_STARTUP_NS*1000/CLK_PERIOD_PS) cycles after reset is released, `cke` is 0 and the command is DESELECT (`cs_n`=1).
- R2: `cke` rises once and then stays high. The first cycle with `cke` high carries a NOP, and the first PRECHARGE ALL follows in the next cycle.
- R3: The only executable commands are issued in this fixed order: PRECHARGE ALL, extended mode load, mode load with DLL reset, PRECHARGE ALL, AUTO REFRESH, AUTO REFRESH, final mode load.
- R4: Commands are encoded as {cs_n,ras_n,cas_n,we_n}: NOP 0111, PRECHARGE 0010, AUTO REFRESH 0001, LOAD MODE 0000. A PRECHARGE ALL drives address bit 10 high, with bank 0 and all other address bits 0. An AUTO REFRESH drives address 0 and bank 0.
- R5: The extended mode load drives bank {BA1,BA0}=01 and the address EMR_VAL with bit 0 forced to 0, which enables the DLL.
- R6: Both mode loads drive bank 00 with the address MODE_VAL. The first forces address bit 8 (DLL reset) to 1, and the final one forces it to 0. The final load never comes before the DLL-reset load.
- R7: The next executable command comes exactly max(ceil(t*1000/CLK_PERIOD_PS),2) cycles after the previous one. Here t is T_RP_NS after a precharge, T_MRD_NS after a mode load and T_RFC_NS after a refresh. Every cycle between two executable commands carries a NOP.
- R8: `init_done` first rises in cycle max(t_final + S_MRD, t_dllrst + DLL_LOCK_CYC + 1) and then stays high. Here S_MRD is the mode-load spacing from R7, and t_final and t_dllrst are the cycles of the final and the DLL-reset mode loads. While `init_done` is high, `cke` is 1 and the command is NOP.
- R9: A synchronous reset at any point returns the outputs to the R1 state and clears `init_done`. The full sequence then restarts with a fresh start-up wait of N cycles.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Controller clock |
| rst | input | 1 | Synchronous reset, active high |
| cke | output | 1 | DRAM clock enable |
| cs_n | output | 1 | Chip select, active low |
| ras_n | output | 1 | Row strobe, active low |
| cas_n | output | 1 | Column strobe, active low |
| we_n | output | 1 | Write enable, active low |
| ba | output | BA_W | Bank address |
| addr | output | ADDR_W | Address lines |
| init_done | output | 1 | Normal operation may begin |

## Verification
The hardest situation to reach is the one where the two limits on `init_done` trade places. Either the DLL-lock window still holds the flag after the command sequence has ended, or the mode-load spacing is the later limit. With a single parameter set only one of these ever occurs. The bench therefore drives two instances from the same reset. One has a 200-cycle lock window and the other a 10-cycle window with a mode-load time short enough to hit the two-cycle spacing floor. A second corner is a reset issued partway through the sequence, after the extended mode load. The bench times this by watching the command bus and then checks that a full start-up wait follows.

// File: rtl/ddr_pwrup_pkg.sv
package ddr_pwrup_pkg;

   // {cs_n, ras_n, cas_n, we_n}
   typedef enum logic [3:0] {
      CMD_LMR = 4'b0000,
      CMD_REF = 4'b0001,
      CMD_PRE = 4'b0010,
      CMD_NOP = 4'b0111,
      CMD_DES = 4'b1111
   } dram_cmd_e;

   typedef enum logic [3:0] {
      ST_STARTUP,
      ST_CKE_UP,
      ST_PRE_A,
      ST_LD_EXT,
      ST_LD_DLLRST,
      ST_PRE_B,
      ST_REF_A,
      ST_REF_B,
      ST_LD_FINAL,
      ST_GAP,
      ST_READY
   } seq_state_e;

   // nanoseconds to clock cycles, rounded up
   function automatic int unsigned ns_to_cyc(input int unsigned ns, input int unsigned ps);
      return (ns * 1000 + ps - 1) / ps;
   endfunction

   // NOP cycles to hold after a command so the next lands max(w,2) cycles later
   function automatic int unsigned gap_len(input int unsigned ns, input int unsigned ps);
      int unsigned w;
      w = ns_to_cyc(ns, ps);
      return (w < 2) ? 1 : w - 1;
   endfunction

   function automatic int unsigned umax(input int unsigned a, input int unsigned b);
      return (a > b) ? a : b;
   endfunction

   function automatic logic is_cmd_state(input seq_state_e s);
      return (s == ST_PRE_A) || (s == ST_LD_EXT) || (s == ST_LD_DLLRST) ||
             (s == ST_PRE_B) || (s == ST_REF_A) || (s == ST_REF_B) ||
             (s == ST_LD_FINAL);
   endfunction

   function automatic seq_state_e succ_state(input seq_state_e s);
      case (s)
         ST_PRE_A:     return ST_LD_EXT;
         ST_LD_EXT:    return ST_LD_DLLRST;
         ST_LD_DLLRST: return ST_PRE_B;
         ST_PRE_B:     return ST_REF_A;
         ST_REF_A:     return ST_REF_B;
         ST_REF_B:     return ST_LD_FINAL;
         ST_LD_FINAL:  return ST_READY;
         default:      return ST_STARTUP;
      endcase
   endfunction

endpackage

// File: rtl/ddr_pwrup_tmr.sv
module ddr_pwrup_tmr #(
   parameter int CNT_W   = 8,
   parameter int RST_VAL = 1
) (
   input  logic             clk,
   input  logic             rst,
   input  logic             load,
   input  logic [CNT_W-1:0] load_val,
   input  logic             dec,
   output logic             last
);

   if (RST_VAL < 1) begin : g_bad_rst
      $error("ddr_pwrup_tmr: RST_VAL must be at least 1");
   end
   if (RST_VAL >= (2 ** CNT_W)) begin : g_bad_w
      $error("ddr_pwrup_tmr: CNT_W too narrow for RST_VAL");
   end

   localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

   logic [CNT_W-1:0] cnt_q;

   always_ff @(posedge clk) begin
      if (rst)
         cnt_q <= CNT_W'(RST_VAL);
      else if (load)
         cnt_q <= load_val;
      else if (dec && (cnt_q > ONE))
         cnt_q <= cnt_q - ONE;
   end

   assign last = (cnt_q == ONE);

   // R7
   tmr_nonzero_chk: assert property (@(posedge clk) disable iff (rst)
      cnt_q != '0);

   // R7
   tmr_load_chk: assert property (@(posedge clk) disable iff (rst)
      load |-> (load_val != '0));

endmodule

// File: rtl/ddr_pwrup_dllwin.sv
module ddr_pwrup_dllwin #(
   parameter int LOCK_CYC = 200
) (
   input  logic clk,
   input  logic rst,
   input  logic start,
   output logic armed,
   output logic ok
);

   if (LOCK_CYC < 1) begin : g_bad_lock
      $error("ddr_pwrup_dllwin: LOCK_CYC must be at least 1");
   end

   localparam int LW = $clog2(LOCK_CYC + 1);
   localparam logic [LW-1:0] LOCK_V = LW'(LOCK_CYC);
   localparam logic [LW-1:0] ONE = LW'(1);

   logic [LW-1:0] cnt_q;

   always_ff @(posedge clk) begin
      if (rst)
         cnt_q <= '0;
      else if (start)
         cnt_q <= ONE;
      else if ((cnt_q != '0) && (cnt_q != LOCK_V))
         cnt_q <= cnt_q + ONE;
   end

   assign armed = (cnt_q != '0);
   assign ok    = (cnt_q == LOCK_V);

   // R8
   lock_hold_chk: assert property (@(posedge clk) disable iff (rst)
      (ok && !start) |=> ok);

endmodule

// File: rtl/ddr_pwrup_cmdenc.sv
module ddr_pwrup_cmdenc
   import ddr_pwrup_pkg::*;
#(
   parameter int                ADDR_W        = 13,
   parameter int                BA_W          = 2,
   parameter logic [ADDR_W-1:0] MODE_VAL      = '0,
   parameter logic [ADDR_W-1:0] EMR_VAL       = '0,
   parameter bit                IDLE_DESELECT = 1'b1
) (
   input  seq_state_e        state,
   output logic              cke,
   output dram_cmd_e         cmd,
   output logic [BA_W-1:0]   ba,
   output logic [ADDR_W-1:0] addr
);

   localparam int BIT_ALLBANK = 10;
   localparam int BIT_DLLRST  = 8;
   localparam int BIT_DLLDIS  = 0;

   if (ADDR_W <= BIT_ALLBANK) begin : g_bad_addr
      $error("ddr_pwrup_cmdenc: ADDR_W must exceed 10");
   end
   if (BA_W < 2) begin : g_bad_ba
      $error("ddr_pwrup_cmdenc: BA_W must be at least 2");
   end

   localparam logic [ADDR_W-1:0] M_ALLBANK = ADDR_W'(1) << BIT_ALLBANK;
   localparam logic [ADDR_W-1:0] M_DLLRST  = ADDR_W'(1) << BIT_DLLRST;
   localparam logic [ADDR_W-1:0] M_DLLDIS  = ADDR_W'(1) << BIT_DLLDIS;
   localparam logic [ADDR_W-1:0] A_MR_RST  = MODE_VAL | M_DLLRST;
   localparam logic [ADDR_W-1:0] A_MR_RUN  = MODE_VAL & ~M_DLLRST;
   localparam logic [ADDR_W-1:0] A_EMR     = EMR_VAL & ~M_DLLDIS;
   localparam logic [BA_W-1:0]   BA_EXT    = BA_W'(1);
   localparam logic [BA_W-1:0]   BA_MODE   = '0;

   dram_cmd_e idle_cmd;

   if (IDLE_DESELECT) begin : g_idle_des
      assign idle_cmd = CMD_DES;
   end else begin : g_idle_nop
      assign idle_cmd = CMD_NOP;
   end

   always_comb begin
      cke  = 1'b1;
      cmd  = CMD_NOP;
      ba   = '0;
      addr = '0;
      case (state)
         ST_STARTUP: begin
            cke = 1'b0;
            cmd = idle_cmd;
         end
         ST_PRE_A, ST_PRE_B: begin
            cmd  = CMD_PRE;
            addr = M_ALLBANK;
         end
         ST_LD_EXT: begin
            cmd  = CMD_LMR;
            ba   = BA_EXT;
            addr = A_EMR;
         end
         ST_LD_DLLRST: begin
            cmd  = CMD_LMR;
            ba   = BA_MODE;
            addr = A_MR_RST;
         end
         ST_REF_A, ST_REF_B: begin
            cmd = CMD_REF;
         end
         ST_LD_FINAL: begin
            cmd  = CMD_LMR;
            ba   = BA_MODE;
            addr = A_MR_RUN;
         end
         default: begin
            cmd = CMD_NOP;
         end
      endcase
   end

endmodule

// File: rtl/ddr_pwrup_seq.sv
module ddr_pwrup_seq
   import ddr_pwrup_pkg::*;
#(
   parameter int                CLK_PERIOD_PS = 4000,
   parameter int                T_STARTUP_NS  = 200000,
   parameter int                T_RP_NS       = 15,
   parameter int                T_MRD_NS      = 12,
   parameter int                T_RFC_NS      = 70,
   parameter int                DLL_LOCK_CYC  = 200,
   parameter int                ADDR_W        = 13,
   parameter int                BA_W          = 2,
   parameter logic [ADDR_W-1:0] MODE_VAL      = 'h032,
   parameter logic [ADDR_W-1:0] EMR_VAL       = '0,
   parameter bit                IDLE_DESELECT = 1'b1
) (
   input  logic              clk,
   input  logic              rst,
   output logic              cke,
   output logic              cs_n,
   output logic              ras_n,
   output logic              cas_n,
   output logic              we_n,
   output logic [BA_W-1:0]   ba,
   output logic [ADDR_W-1:0] addr,
   output logic              init_done
);

   if (CLK_PERIOD_PS < 1) begin : g_bad_clk
      $error("ddr_pwrup_seq: CLK_PERIOD_PS must be positive");
   end
   if (DLL_LOCK_CYC < 1) begin : g_bad_dll
      $error("ddr_pwrup_seq: DLL_LOCK_CYC must be positive");
   end

   localparam int unsigned N_START = umax(ns_to_cyc(T_STARTUP_NS, CLK_PERIOD_PS), 1);
   localparam int unsigned G_RP    = gap_len(T_RP_NS, CLK_PERIOD_PS);
   localparam int unsigned G_MRD   = gap_len(T_MRD_NS, CLK_PERIOD_PS);
   localparam int unsigned G_RFC   = gap_len(T_RFC_NS, CLK_PERIOD_PS);
   localparam int unsigned CNT_MAX = umax(umax(N_START, G_RP), umax(G_MRD, G_RFC));
   localparam int          CNT_W   = $clog2(CNT_MAX + 1);

   seq_state_e       state_q, state_d;
   seq_state_e       ret_q, ret_d;
   logic             t_load, t_dec, t_last;
   logic [CNT_W-1:0] t_val;
   logic             dll_start, dll_armed, dll_ok;
   dram_cmd_e        cmd;
   logic             exec_cmd;

   // ---------------- sequencing ----------------
   always_comb begin
      state_d = state_q;
      ret_d   = ret_q;
      case (state_q)
         ST_STARTUP: if (t_last) state_d = ST_CKE_UP;
         ST_CKE_UP:  state_d = ST_PRE_A;
         ST_PRE_A, ST_LD_EXT, ST_LD_DLLRST, ST_PRE_B,
         ST_REF_A, ST_REF_B, ST_LD_FINAL: begin
            state_d = ST_GAP;
            ret_d   = succ_state(state_q);
         end
         ST_GAP: if (t_last && ((ret_q != ST_READY) || dll_ok)) state_d = ret_q;
         ST_READY:   state_d = ST_READY;
         default:    state_d = ST_STARTUP;
      endcase
   end

   always_ff @(posedge clk) begin
      if (rst) begin
         state_q <= ST_STARTUP;
         ret_q   <= ST_PRE_A;
      end else begin
         state_q <= state_d;
         ret_q   <= ret_d;
      end
   end

   // ---------------- wait timing ----------------
   always_comb begin
      case (state_q)
         ST_PRE_A, ST_PRE_B:                  t_val = CNT_W'(G_RP);
         ST_REF_A, ST_REF_B:                  t_val = CNT_W'(G_RFC);
         ST_LD_EXT, ST_LD_DLLRST, ST_LD_FINAL: t_val = CNT_W'(G_MRD);
         default:                             t_val = CNT_W'(1);
      endcase
   end

   assign t_load    = is_cmd_state(state_q);
   assign t_dec     = (state_q == ST_STARTUP) || (state_q == ST_GAP);
   assign dll_start = (state_q == ST_LD_DLLRST);

   ddr_pwrup_tmr #(
      .CNT_W   (CNT_W),
      .RST_VAL (int'(N_START))
   ) u_tmr (
      .clk      (clk),
      .rst      (rst),
      .load     (t_load),
      .load_val (t_val),
      .dec      (t_dec),
      .last     (t_last)
   );

   ddr_pwrup_dllwin #(
      .LOCK_CYC (DLL_LOCK_CYC)
   ) u_dll (
      .clk   (clk),
      .rst   (rst),
      .start (dll_start),
      .armed (dll_armed),
      .ok    (dll_ok)
   );

   // ---------------- command bus ----------------
   ddr_pwrup_cmdenc #(
      .ADDR_W        (ADDR_W),
      .BA_W          (BA_W),
      .MODE_VAL      (MODE_VAL),
      .EMR_VAL       (EMR_VAL),
      .IDLE_DESELECT (IDLE_DESELECT)
   ) u_enc (
      .state (state_q),
      .cke   (cke),
      .cmd   (cmd),
      .ba    (ba),
      .addr  (addr)
   );

   assign {cs_n, ras_n, cas_n, we_n} = cmd;
   assign init_done = (state_q == ST_READY);
   assign exec_cmd  = (cmd != CMD_NOP) && (cmd != CMD_DES);

   // ---------------- checks ----------------
   // R1
   quiet_startup_chk: assert property (@(posedge clk) disable iff (rst)
      !cke |-> !exec_cmd);

   // R2
   cke_hold_chk: assert property (@(posedge clk) disable iff (rst)
      cke |=> cke);

   // R7
   nop_after_cmd_chk: assert property (@(posedge clk) disable iff (rst)
      exec_cmd |=> (cmd == CMD_NOP));

   // R6
   final_after_rst_chk: assert property (@(posedge clk) disable iff (rst)
      (cmd == CMD_LMR && ba == '0 && !addr[8]) |-> dll_armed);

   // R8
   done_dll_chk: assert property (@(posedge clk) disable iff (rst)
      init_done |-> dll_ok);

   // R8
   done_hold_chk: assert property (@(posedge clk) disable iff (rst)
      init_done |=> init_done);

   // R8
   done_quiet_chk: assert property (@(posedge clk) disable iff (rst)
      init_done |-> (cke && cmd == CMD_NOP));

endmodule

// File: tb/tb_ddr_pwrup_seq.sv
module tb_ddr_pwrup_seq;

   localparam int PER_PS = 4000;

   logic clk = 1'b0;
   logic rst = 1'b1;
   always #2 clk = ~clk;

   // instance A: long DLL window, instance B: short window, tMRD at floor
   logic        cke_a, cs_a, ras_a, cas_a, we_a, done_a;
   logic [1:0]  ba_a;
   logic [12:0] addr_a;
   logic        cke_b, cs_b, ras_b, cas_b, we_b, done_b;
   logic [1:0]  ba_b;
   logic [12:0] addr_b;

   ddr_pwrup_seq #(
      .CLK_PERIOD_PS (PER_PS), .T_STARTUP_NS (200), .T_RP_NS (15),
      .T_MRD_NS (12), .T_RFC_NS (70), .DLL_LOCK_CYC (200),
      .MODE_VAL (13'h0032), .EMR_VAL (13'h0001)
   ) dut (
      .clk (clk), .rst (rst), .cke (cke_a), .cs_n (cs_a), .ras_n (ras_a),
      .cas_n (cas_a), .we_n (we_a), .ba (ba_a), .addr (addr_a), .init_done (done_a)
   );

   ddr_pwrup_seq #(
      .CLK_PERIOD_PS (PER_PS), .T_STARTUP_NS (120), .T_RP_NS (15),
      .T_MRD_NS (2), .T_RFC_NS (70), .DLL_LOCK_CYC (10),
      .MODE_VAL (13'h0132), .EMR_VAL (13'h0002)
   ) dut_b (
      .clk (clk), .rst (rst), .cke (cke_b), .cs_n (cs_b), .ras_n (ras_b),
      .cas_n (cas_b), .we_n (we_b), .ba (ba_b), .addr (addr_b), .init_done (done_b)
   );

   logic        sel = 1'b0;
   logic        m_cke, m_done;
   logic [3:0]  m_cmd;
   logic [1:0]  m_ba;
   logic [12:0] m_addr;
   assign m_cke  = sel ? cke_b : cke_a;
   assign m_done = sel ? done_b : done_a;
   assign m_cmd  = sel ? {cs_b, ras_b, cas_b, we_b} : {cs_a, ras_a, cas_a, we_a};
   assign m_ba   = sel ? ba_b : ba_a;
   assign m_addr = sel ? addr_b : addr_a;

   localparam logic [3:0] C_NOP = 4'b0111, C_PRE = 4'b0010,
                          C_REF = 4'b0001, C_LMR = 4'b0000;

   // expected command walk: command, bank
   localparam logic [3:0] EXP_CMD [0:6] = '{C_PRE, C_LMR, C_LMR, C_PRE, C_REF, C_REF, C_LMR};
   localparam logic [1:0] EXP_BA  [0:6] = '{2'd0, 2'd1, 2'd0, 2'd0, 2'd0, 2'd0, 2'd0};

   int checks = 0;
   int errors = 0;
   int smp = 0;

   task automatic step();
      @(negedge clk);
      smp++;
   endtask

   task automatic chk(input bit ok, input string req, input int act, input int exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   function automatic int sp(input int ns);
      int w;
      w = (ns * 1000 + PER_PS - 1) / PER_PS;
      return (w < 2) ? 2 : w;
   endfunction

   function automatic int imax(input int a, input int b);
      return (a > b) ? a : b;
   endfunction

   task automatic count_startup(input int n_start);
      int cnt;
      cnt = 0;
      while (!m_cke && cnt < 5000) begin
         chk(m_cmd[3] == 1'b1, "R1 deselect during wait", m_cmd, 4'b1111);
         cnt++;
         step();
      end
      chk(cnt == n_start, "R1 cke-low cycles", cnt, n_start);
   endtask

   task automatic run_seq(input bit which, input int n_start, input int t_mrd,
                          input int lock, input logic [12:0] mode, input logic [12:0] emr);
      int t_prev, t_rst, t_fin, d, exp_d, exp_done, guard;
      logic [12:0] exp_a;
      sel = which;
      rst = 1'b1;
      repeat (3) step();
      // R9 reset state
      chk(m_cke == 1'b0, "R9 cke in reset", m_cke, 0);
      chk(m_done == 1'b0, "R9 done in reset", m_done, 0);
      chk(m_cmd == 4'b1111, "R1 deselect in reset", m_cmd, 4'b1111);
      rst = 1'b0;
      count_startup(n_start);
      chk(m_cmd == C_NOP, "R2 nop with cke rise", m_cmd, C_NOP);
      t_prev = smp;
      t_rst = 0;
      t_fin = 0;
      exp_d = 1;
      step();
      for (int k = 0; k < 7; k++) begin
         guard = 0;
         while (m_cmd == C_NOP && guard < 1000) begin
            guard++;
            step();
         end
         d = smp - t_prev;
         chk(d == exp_d, "R7 command spacing", d, exp_d);
         chk(m_cmd == EXP_CMD[k], "R3 command order", m_cmd, EXP_CMD[k]);
         chk(m_cke == 1'b1, "R2 cke stays high", m_cke, 1);
         case (k)
            0, 3: exp_a = 13'h0400;
            1:    exp_a = emr & ~13'h0001;
            2:    exp_a = mode | 13'h0100;
            6:    exp_a = mode & ~13'h0100;
            default: exp_a = 13'h0000;
         endcase
         chk(m_ba == EXP_BA[k],
             (k == 1) ? "R5 ext bank" : (k == 2 || k == 6) ? "R6 mode bank" : "R4 bank", m_ba, EXP_BA[k]);
         chk(m_addr == exp_a,
             (k == 1) ? "R5 ext addr" : (k == 2 || k == 6) ? "R6 mode addr" : "R4 addr", m_addr, exp_a);
         if (k == 2) t_rst = smp;
         if (k == 6) t_fin = smp;
         if (EXP_CMD[k] == C_PRE) exp_d = sp(15);
         else if (EXP_CMD[k] == C_REF) exp_d = sp(70);
         else exp_d = sp(t_mrd);
         t_prev = smp;
         step();
      end
      guard = 0;
      while (!m_done && guard < 1000) begin
         if (m_cmd != C_NOP) chk(1'b0, "R7 nop before done", m_cmd, C_NOP);
         guard++;
         step();
      end
      exp_done = imax(t_fin + sp(t_mrd), t_rst + lock + 1);
      chk(smp == exp_done, "R8 done timing", smp - t_rst, exp_done - t_rst);
      for (int i = 0; i < 8; i++) begin
         chk(m_done && m_cke && m_cmd == C_NOP, "R8 done held quiet",
             {m_done, m_cke, m_cmd}, {1'b1, 1'b1, C_NOP});
         step();
      end
   endtask

   initial begin
      repeat (2) step();
      run_seq(1'b0, 50, 12, 200, 13'h0032, 13'h0001);
      run_seq(1'b1, 30, 2, 10, 13'h0132, 13'h0002);

      // R9: reset in the middle of the sequence, after the extended mode load
      sel = 1'b0;
      rst = 1'b1;
      repeat (3) step();
      rst = 1'b0;
      while (!m_cke) step();
      while (!(m_cmd == C_LMR && m_ba == 2'd1)) step();
      repeat (2) step();
      rst = 1'b1;
      step();
      chk(m_cke == 1'b0, "R9 cke after mid reset", m_cke, 0);
      chk(m_cmd == 4'b1111, "R9 deselect after mid reset", m_cmd, 4'b1111);
      chk(m_done == 1'b0, "R9 done after mid reset", m_done, 0);
      rst = 1'b0;
      count_startup(50);
      chk(m_cmd == C_NOP, "R9 restart nop", m_cmd, C_NOP);
      step();
      chk(m_cmd == C_PRE && m_addr == 13'h0400, "R9 restart precharge", m_cmd, C_PRE);

      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

   initial begin
      repeat (50000) @(posedge clk);
      checks++;
      errors++;
      $display("FAIL watchdog expired actual=%0d expected=%0d", 50000, 0);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

endmodule